// File: doc/BRIEF.md
# Console Memory Examine/Deposit Controller

This block sits behind an operator console and lets a person inspect and change main memory one word at a time. It keeps a current-address register and turns debounced button levels into memory read and write cycles. The word read back is latched so the console lamps can show the address and its contents. Stepping forward or back, jumping to a keyed-in address and storing a keyed-in word each end with a fresh read. A store therefore leaves the display on the following location.

The controller only services the buttons in programming mode. In halt mode the same store and load-address buttons put the entry switches straight onto the internal data or address bus for as long as they are held. This path involves no memory cycle and no register. When a run is requested, the block supplies the start address. From programming mode this is the current address. From halt it is the program counter value supplied by the core.

Memory accesses use a request/ready handshake, so slow memory can stretch any cycle. While an access is outstanding, new button presses are dropped.

Top module: `console_memctl`

## Requirements
- R1: After reset the displayed address and data are 0, no memory request is active, no start pulse is issued and neither bus drive is enabled.
- R2: When the mode input changes to programming (mode code 1) from any other code, the address register is loaded from `defaultAddr` and that location is read, so the display shows the default address and its contents.
- R3: A rising edge on `btnNext` in programming mode adds 1 to the address modulo 2^16 (0xFFFF becomes 0x0000) and reads the new location.
- R4: A rising edge on `btnPrev` in programming mode subtracts 1 from the address modulo 2^16 (0x0000 becomes 0xFFFF) and reads the new location.
- R5: A rising edge on `btnLoad` in programming mode copies `entrySw` into the address register and reads that location.
- R6: A rising edge on `btnDeposit` in programming mode writes `entrySw` to the current address, then adds 1 to the address modulo 2^16 and reads the new location. The display ends on the following location, not the one written.
- R7: Each access holds `memReq`, `memWe`, `memAddr` and `memWdata` steady until `memReady` is sampled high. The read data is latched only on a ready cycle. Button edges that arrive while an access is outstanding are discarded.
- R8: When several button edges arrive in the same cycle, only one is served, in the order load-address, then deposit, then next, then previous.
- R9: In run (code 2), slow (code 3) and step (code 4) modes, button edges start no memory access and leave the display unchanged.
- R10: In halt mode (code 0), `dataBusEn` follows `btnDeposit` and `addrBusEn` follows `btnLoad`, each driving `entrySw` onto its bus. Next and previous do nothing, and no memory access or display change results.
- R11: A `runReq` pulse in programming mode gives a one-cycle `startValid` on the next cycle, with `startAddr` equal to the address register. In halt mode it gives `startAddr` equal to `pcIn`. In run, slow and step modes it gives no `startValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Operating mode: 0 halt, 1 programming, 2 run, 3 slow, 4 step |
| defaultAddr | input | 16 | Address loaded on entry to programming mode |
| entrySw | input | 16 | Entry switch value |
| btnNext | input | 1 | Debounced examine-next button level |
| btnPrev | input | 1 | Debounced examine-previous button level |
| btnLoad | input | 1 | Debounced load-address button level |
| btnDeposit | input | 1 | Debounced deposit button level |
| runReq | input | 1 | One-cycle request to start execution |
| pcIn | input | 16 | Current program counter value |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Access address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memReady |
| memReady | input | 1 | Access complete |
| dispAddr | output | 16 | Address shown on the console |
| dispData | output | 16 | Latched contents shown on the console |
| dataBusEn | output | 1 | Halt-mode drive enable for the internal data bus |
| dataBusVal | output | 16 | Value for the internal data bus |
| addrBusEn | output | 1 | Halt-mode drive enable for the internal address bus |
| addrBusVal | output | 16 | Value for the internal address bus |
| startValid | output | 1 | One-cycle start pulse |
| startAddr | output | 16 | Address at which execution starts |

## Verification
The bench drives the address across 0xFFFF in both directions. A design that stepped with a wider or narrower adder would show the wrong address there, or stale data after the wrap. Deposits are read back by stepping backwards. A design that incremented before writing, or that skipped the re-read, would show the written word one location off, or show stale data. The bench presses a second button in the middle of a stretched access and presses buttons together, to catch a design that queues edges or uses the wrong priority. It also re-enters programming mode and issues run requests from every mode, to catch a missing default reload or a start address taken from the wrong source.

// File: rtl/console_pkg.sv
`timescale 1ns/1ps
package console_pkg;

  typedef enum logic [2:0] {
    MODE_HALT = 3'd0,
    MODE_PROG = 3'd1,
    MODE_RUN  = 3'd2,
    MODE_SLOW = 3'd3,
    MODE_STEP = 3'd4
  } panelMode_e;

  // Strobes from the sequencer to the datapath, one cycle each.
  typedef struct packed {
    logic loadDefault;
    logic loadEntry;
    logic stepUp;
    logic stepDown;
    logic captureWrite;
    logic latchRead;
  } dpStrobe_t;

  // Button indices in the edge-detect vector.
  localparam int unsigned BTN_COUNT = 4;
  localparam int unsigned BTN_LOAD  = 3;
  localparam int unsigned BTN_DEP   = 2;
  localparam int unsigned BTN_NEXT  = 1;
  localparam int unsigned BTN_PREV  = 0;

endpackage

// File: rtl/console_ctrl.sv
`timescale 1ns/1ps
module console_ctrl
  import console_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           mode,
  input  logic [BTN_COUNT-1:0] btnLevel,
  input  logic                 memReady,
  output dpStrobe_t            strobe,
  output logic                 memReq,
  output logic                 memWe
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seqState_e;

  seqState_e            state, nextState;
  panelMode_e           modeNow;
  logic                 wasProg;
  logic                 enterPend;
  logic [BTN_COUNT-1:0] btnQ;
  logic [BTN_COUNT-1:0] btnEdge;
  logic                 inProg;
  logic                 entryWanted;
  logic                 entryTaken;

  assign modeNow     = panelMode_e'(mode);
  assign inProg      = (modeNow == MODE_PROG);
  assign entryWanted = inProg && (enterPend || !wasProg);

  // One rising-edge detector per button.
  for (genvar b = 0; b < BTN_COUNT; b++) begin : gEdge
    always_ff @(posedge clk) begin
      if (!rstN) btnQ[b] <= 1'b0;
      else       btnQ[b] <= btnLevel[b];
    end
    assign btnEdge[b] = btnLevel[b] & ~btnQ[b];
  end

  always_comb begin
    strobe     = '0;
    nextState  = state;
    memReq     = 1'b0;
    memWe      = 1'b0;
    entryTaken = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (entryWanted) begin
          strobe.loadDefault = 1'b1;
          entryTaken         = 1'b1;
          nextState          = ST_READ;
        end else if (inProg) begin
          if (btnEdge[BTN_LOAD]) begin
            strobe.loadEntry = 1'b1;
            nextState        = ST_READ;
          end else if (btnEdge[BTN_DEP]) begin
            strobe.captureWrite = 1'b1;
            nextState           = ST_WRITE;
          end else if (btnEdge[BTN_NEXT]) begin
            strobe.stepUp = 1'b1;
            nextState     = ST_READ;
          end else if (btnEdge[BTN_PREV]) begin
            strobe.stepDown = 1'b1;
            nextState       = ST_READ;
          end
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memReady) begin
          strobe.latchRead = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          strobe.stepUp = 1'b1;
          nextState     = ST_READ;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wasProg   <= 1'b0;
      enterPend <= 1'b0;
    end else begin
      state   <= nextState;
      wasProg <= inProg;
      if (!inProg || entryTaken) enterPend <= 1'b0;
      else if (entryWanted)      enterPend <= 1'b1;
    end
  end

  // R9: an access only ever starts from a programming-mode event.
  assert_prog_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> ($past(mode) == MODE_PROG));

  // R6: a completed write is followed at once by a read.
  assert_write_then_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memReady) |=> (memReq && !memWe));

endmodule

// File: rtl/console_dp.sv
`timescale 1ns/1ps
module console_dp
  import console_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] defaultAddr,
  input  logic [ADDR_W-1:0] entryAddr,
  input  logic [DATA_W-1:0] entryData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] dataReg,
  output logic [DATA_W-1:0] wdataReg
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobe.loadDefault) begin
      addrReg <= defaultAddr;
    end else if (strobe.loadEntry) begin
      addrReg <= entryAddr;
    end else if (strobe.stepUp) begin
      addrReg <= addrReg + ADDR_ONE;
    end else if (strobe.stepDown) begin
      addrReg <= addrReg - ADDR_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdataReg <= '0;
      dataReg  <= '0;
    end else begin
      if (strobe.captureWrite) wdataReg <= entryData;
      if (strobe.latchRead)    dataReg  <= memRdata;
    end
  end

  // R7: displayed data only changes on a cycle where memory reported ready.
  assert_latch_on_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataReg) |-> $past(memReady));

endmodule

// File: rtl/console_launch.sv
`timescale 1ns/1ps
module console_launch
  import console_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic              runReq,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [DATA_W-1:0] entrySw,
  input  logic              holdData,
  input  logic              holdAddr,
  output logic              startValid,
  output logic [ADDR_W-1:0] startAddr,
  output logic              dataBusEn,
  output logic [DATA_W-1:0] dataBusVal,
  output logic              addrBusEn,
  output logic [ADDR_W-1:0] addrBusVal
);

  panelMode_e modeNow;
  logic       isHalt;
  logic       isProg;

  assign modeNow = panelMode_e'(mode);
  assign isHalt  = (modeNow == MODE_HALT);
  assign isProg  = (modeNow == MODE_PROG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startValid <= 1'b0;
      startAddr  <= '0;
    end else begin
      startValid <= runReq && (isProg || isHalt);
      if (runReq && isProg)      startAddr <= addrReg;
      else if (runReq && isHalt) startAddr <= pcIn;
    end
  end

  // Halt-mode pass-through: live switches, nothing stored.
  assign dataBusEn  = isHalt && holdData;
  assign addrBusEn  = isHalt && holdAddr;
  assign dataBusVal = entrySw;
  assign addrBusVal = entrySw[ADDR_W-1:0];

  // R11: a start pulse is always the answer to a request one cycle earlier.
  assert_start_after_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> $past(runReq));

endmodule

// File: rtl/console_memctl.sv
`timescale 1ns/1ps
module console_memctl
  import console_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] defaultAddr,
  input  logic [DATA_W-1:0] entrySw,
  input  logic              btnNext,
  input  logic              btnPrev,
  input  logic              btnLoad,
  input  logic              btnDeposit,
  input  logic              runReq,
  input  logic [ADDR_W-1:0] pcIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [ADDR_W-1:0] dispAddr,
  output logic [DATA_W-1:0] dispData,
  output logic              dataBusEn,
  output logic [DATA_W-1:0] dataBusVal,
  output logic              addrBusEn,
  output logic [ADDR_W-1:0] addrBusVal,
  output logic              startValid,
  output logic [ADDR_W-1:0] startAddr
);

  dpStrobe_t            strobe;
  logic [BTN_COUNT-1:0] btnLevel;
  logic [ADDR_W-1:0]    addrReg;
  logic [DATA_W-1:0]    dataReg;
  logic [DATA_W-1:0]    wdataReg;

  assign btnLevel = {btnLoad, btnDeposit, btnNext, btnPrev};

  console_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .btnLevel (btnLevel),
    .memReady (memReady),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  console_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .defaultAddr (defaultAddr),
    .entryAddr   (entrySw[ADDR_W-1:0]),
    .entryData   (entrySw),
    .memRdata    (memRdata),
    .memReady    (memReady),
    .addrReg     (addrReg),
    .dataReg     (dataReg),
    .wdataReg    (wdataReg)
  );

  console_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uLaunch (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .runReq     (runReq),
    .pcIn       (pcIn),
    .addrReg    (addrReg),
    .entrySw    (entrySw),
    .holdData   (btnDeposit),
    .holdAddr   (btnLoad),
    .startValid (startValid),
    .startAddr  (startAddr),
    .dataBusEn  (dataBusEn),
    .dataBusVal (dataBusVal),
    .addrBusEn  (addrBusEn),
    .addrBusVal (addrBusVal)
  );

  assign memAddr  = addrReg;
  assign memWdata = wdataReg;
  assign dispAddr = addrReg;
  assign dispData = dataReg;

  // R7: an outstanding access keeps its request, direction and operands.
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

endmodule

// File: tb/console_memctl_test.sv
`timescale 1ns/1ps
module console_memctl_test;

  localparam int LAT = 3;
  localparam logic [15:0] DEF_ADDR = 16'h0100;
  localparam int NVEC = 12;
  // {action[2:0], switches[15:0], expected address[15:0]}; 1 next, 2 prev, 3 load, 4 deposit
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd3, 16'hFFFF, 16'hFFFF},
    {3'd1, 16'h0000, 16'h0000},
    {3'd2, 16'h0000, 16'hFFFF},
    {3'd2, 16'h0000, 16'hFFFE},
    {3'd3, 16'h0010, 16'h0010},
    {3'd4, 16'h1234, 16'h0011},
    {3'd4, 16'hBEEF, 16'h0012},
    {3'd2, 16'h0000, 16'h0011},
    {3'd2, 16'h0000, 16'h0010},
    {3'd3, 16'hFFFF, 16'hFFFF},
    {3'd4, 16'h7777, 16'h0000},
    {3'd2, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [15:0] entrySw = '0;
  logic btnNext = 0, btnPrev = 0, btnLoad = 0, btnDeposit = 0, runReq = 0;
  logic [15:0] pcIn = '0;
  logic memReq, memWe, memReady, dataBusEn, addrBusEn, startValid;
  logic [15:0] memAddr, memWdata, memRdata, dispAddr, dispData, dataBusVal, addrBusVal, startAddr;

  int applied = 0, fails = 0, reqCycles = 0, startSeen = 0;
  logic [15:0] startLast = '0;
  logic [15:0] ram [256];
  logic [15:0] refRam [256];
  int waitCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  console_memctl uut (.*);

  function automatic logic [15:0] seedVal(input int i);
    return {8'(i) ^ 8'h5A, ~8'(i)};
  endfunction

  // Memory model with LAT wait cycles before ready.
  always @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      waitCnt  <= 0;
    end else if (memReady) begin
      memReady <= 1'b0;
      waitCnt  <= 0;
    end else if (memReq) begin
      if (waitCnt == LAT) begin
        memReady <= 1'b1;
        if (memWe) ram[memAddr[7:0]] <= memWdata;
        else       memRdata <= ram[memAddr[7:0]];
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (memReq) reqCycles++;
    if (startValid) begin startSeen++; startLast = startAddr; end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic press(input int act, input logic [15:0] sw);
    @(negedge clk);
    entrySw = sw;
    case (act)
      1: btnNext = 1;
      2: btnPrev = 1;
      3: btnLoad = 1;
      default: btnDeposit = 1;
    endcase
    @(negedge clk);
    btnNext = 0; btnPrev = 0; btnLoad = 0; btnDeposit = 0;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] curAddr;
    int reqMark;
    for (int i = 0; i < 256; i++) begin ram[i] = seedVal(i); refRam[i] = seedVal(i); end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dispAddr", dispAddr, 16'h0);
    check("R1 dispData", dispData, 16'h0);
    check("R1 memReq", {15'd0, memReq}, 16'h0);
    check("R1 startValid", {15'd0, startValid}, 16'h0);
    check("R1 busEn", {14'd0, dataBusEn, addrBusEn}, 16'h0);
    rstN = 1;
    @(negedge clk);
    // R2 entry to programming mode
    mode = 3'd1;
    settle();
    check("R2 entry addr", dispAddr, DEF_ADDR);
    check("R2 entry data", dispData, refRam[DEF_ADDR[7:0]]);
    curAddr = DEF_ADDR;

    // Table walk: R3 next, R4 prev, R5 load, R6 deposit
    for (int v = 0; v < NVEC; v++) begin
      int act;
      logic [15:0] sw, ea;
      string tag;
      act = int'(VEC[v][34:32]);
      sw  = VEC[v][31:16];
      ea  = VEC[v][15:0];
      case (act)
        1: tag = "R3 next";
        2: tag = "R4 prev";
        3: tag = "R5 load";
        default: tag = "R6 deposit";
      endcase
      if (act == 4) refRam[curAddr[7:0]] = sw;
      press(act, sw);
      settle();
      check({tag, " addr"}, dispAddr, ea);
      check({tag, " data"}, dispData, refRam[ea[7:0]]);
      curAddr = ea;
    end

    // R7 second press during an outstanding access is dropped
    press(1, 16'h0);
    @(negedge clk); btnNext = 1; @(negedge clk); btnNext = 0;
    settle();
    check("R7 busy press dropped", dispAddr, 16'h0000);
    check("R7 data", dispData, refRam[8'h00]);

    // R8 priority: load beats next, deposit beats next
    @(negedge clk); entrySw = 16'h0042; btnLoad = 1; btnNext = 1;
    @(negedge clk); btnLoad = 0; btnNext = 0;
    settle();
    check("R8 load over next", dispAddr, 16'h0042);
    refRam[8'h42] = 16'h0055;
    @(negedge clk); entrySw = 16'h0055; btnDeposit = 1; btnNext = 1; btnPrev = 1;
    @(negedge clk); btnDeposit = 0; btnNext = 0; btnPrev = 0;
    settle();
    check("R8 deposit over next addr", dispAddr, 16'h0043);
    press(2, 16'h0);
    settle();
    check("R8 deposit written", dispData, 16'h0055);

    // R11 run request from programming mode
    @(negedge clk); runReq = 1; @(negedge clk); runReq = 0;
    settle();
    check("R11 prog start count", 16'(startSeen), 16'd1);
    check("R11 prog start addr", startLast, 16'h0042);

    // R9 ignored in run, slow, step; R11 no start from those
    for (int m = 2; m <= 4; m++) begin
      @(negedge clk); mode = 3'(m);
      reqMark = reqCycles;
      press(1, 16'h0); press(3, 16'h9999); press(4, 16'h1111);
      @(negedge clk); runReq = 1; @(negedge clk); runReq = 0;
      settle();
      check("R9 no access", 16'(reqCycles - reqMark), 16'd0);
      check("R9 display held", dispAddr, 16'h0042);
      check("R11 no start", 16'(startSeen), 16'd1);
    end

    // R10 halt-mode bus drive
    @(negedge clk); mode = 3'd0;
    reqMark = reqCycles;
    @(negedge clk); entrySw = 16'h3C3C; btnDeposit = 1;
    repeat (3) @(negedge clk);
    check("R10 data drive en", {15'd0, dataBusEn}, 16'd1);
    check("R10 data drive val", dataBusVal, 16'h3C3C);
    check("R10 addr idle", {15'd0, addrBusEn}, 16'd0);
    btnDeposit = 0; entrySw = 16'hA1B2; btnLoad = 1;
    @(negedge clk);
    check("R10 data released", {15'd0, dataBusEn}, 16'd0);
    check("R10 addr drive en", {15'd0, addrBusEn}, 16'd1);
    check("R10 addr drive val", addrBusVal, 16'hA1B2);
    btnLoad = 0;
    @(negedge clk);
    check("R10 addr released", {15'd0, addrBusEn}, 16'd0);
    press(1, 16'h0); press(2, 16'h0);
    settle();
    check("R10 no access", 16'(reqCycles - reqMark), 16'd0);
    check("R10 display held", dispAddr, 16'h0042);
    check("R10 data held", dispData, 16'h0055);

    // R11 run request from halt uses PC
    @(negedge clk); pcIn = 16'h2222; runReq = 1; @(negedge clk); runReq = 0;
    settle();
    check("R11 halt start count", 16'(startSeen), 16'd2);
    check("R11 halt start addr", startLast, 16'h2222);

    // R2 re-entry reloads the default address
    @(negedge clk); mode = 3'd1;
    settle();
    check("R2 reentry addr", dispAddr, DEF_ADDR);
    check("R2 reentry data", dispData, refRam[DEF_ADDR[7:0]]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  assign defaultAddr = DEF_ADDR;
  logic [15:0] defaultAddr;

endmodule